// File: doc/BRIEF.md
# Word-zero-extend shift-left-immediate unit

This unit decodes and executes one instruction for a 64-bit register core. The instruction takes the low 32 bits of a source register, clears everything above them, shifts the result left by an immediate amount and writes it to a destination register. The unit takes a 32-bit instruction word and the source operand value. It reports whether the word is this instruction, which destination register the instruction names, the shifted value, and whether the encoding is illegal.

A parameter chooses how the immediate field is read. In the permissive policy the field is seven bits wide and is masked down to the register width, so no immediate value ever traps. In the strict policy the field is a six-bit shift amount and its seventh bit is reserved for a wider register width; a set reserved bit is illegal. With either policy, a build for a 32-bit register width treats every matching encoding as illegal, because the instruction exists only at 64 bits. The unit is purely combinational. It does not access the register file, hold any pipeline state or raise exceptions.

Top module: `wzext_slli`

## Requirements
- R1: When insn[6:0] is not 0011011, or insn[14:12] is not 001 (this includes 101, the right-shift code), or insn[31:27] is not 00001, then hit, rd, result and illegal are all zero.
- R2: When hit is 1 and illegal is 0, result equals the source operand's low 32 bits, zero-extended to the register width, shifted left by the shift amount and truncated to the register width. Source bits above bit 31 have no effect.
- R3: With the permissive policy (LEGACY=1), the shift amount is the 7-bit field insn[26:20] ANDed with XLEN-1. For example, 64 gives a shift of 0 and 127 gives a shift of 63.
- R4: With the permissive policy at XLEN=64, illegal is 0 for every immediate value.
- R5: With the strict policy (LEGACY=0), the shift amount is insn[25:20], which covers 0 to 63.
- R6: With the strict policy, a matching word with insn[26]=1 sets illegal to 1 and result to 0.
- R7: At XLEN=32, every matching word sets illegal to 1 and result to 0, with either policy.
- R8: When hit is 1, rd equals insn[11:7] and the word is reported as a match, even if it is illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word to decode |
| src | input | XLEN | Source operand value |
| hit | output | 1 | The word is this instruction |
| rd | output | 5 | Destination register index, zero when there is no match |
| result | output | XLEN | Shifted value, zero when there is no match or the word is illegal |
| illegal | output | 1 | The matching encoding is illegal |

## Verification
Every output follows its inputs in the same cycle, with no register on the path. A result is therefore due as soon as a stimulus is applied. The bench applies each instruction word and operand just after a rising edge and compares all four outputs against a behavioural model at the following falling edge. This leaves half a period for the inputs to settle before any value is read. Three instances are compared every cycle: the strict policy, the permissive policy and a 32-bit build. The stimulus covers shift amounts 0, 31, 32 and 63, operands with the upper word set, permissive immediates of 64 and above, the reserved strict bit, and words that do not match.

// File: rtl/wzext_slli.sv
module wzext_slli #(
  parameter int XLEN   = 64,
  parameter bit LEGACY = 1'b0
) (
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src,
  output logic            hit,
  output logic [4:0]      rd,
  output logic [XLEN-1:0] result,
  output logic            illegal
);
  localparam bit WIDE_OK = (XLEN == 64);

  logic       base;
  logic [6:0] amt;
  logic       resv;
  logic       bad;
  logic [XLEN-1:0] word;
  logic [XLEN-1:0] shifted;

  assign base = (insn[6:0] == 7'b0011011) && (insn[14:12] == 3'b001)
             && (insn[31:27] == 5'b00001);

  generate
    if (LEGACY) begin : g_mask
      assign amt  = insn[26:20] & 7'(XLEN - 1);
      assign resv = 1'b0;
    end else begin : g_strict
      assign amt  = {1'b0, insn[25:20]};
      assign resv = insn[26];
    end
  endgenerate

  assign bad     = base && (!WIDE_OK || resv);
  assign word    = XLEN'(src[31:0]);
  assign shifted = word << amt;

  assign hit     = base;
  assign rd      = base ? insn[11:7] : 5'd0;
  assign illegal = bad;
  assign result  = (base && !bad) ? shifted : '0;

  wire unused_bits = ^{insn[19:15], src};
endmodule

module wzext_slli_chk #(
  parameter int XLEN   = 64,
  parameter bit LEGACY = 1'b0
) (
  input logic [31:0]     insn,
  input logic [XLEN-1:0] src,
  input logic            hit,
  input logic [4:0]      rd,
  input logic [XLEN-1:0] result,
  input logic            illegal
);
  always_comb begin
    a_r1_idle_zero: assert (hit || (rd == 5'd0 && result == '0 && !illegal))
      else $error("R1 outputs nonzero without a match");
    a_r6_illegal_no_result: assert (!illegal || (hit && result == '0))
      else $error("R6/R7 illegal word produced a result");
    a_r2_bits_bounded: assert (!hit || illegal ||
                               $countones(result) <= $countones(src[31:0]))
      else $error("R2 result holds more bits than the low word");
    a_r8_rd_field: assert (!hit || rd == insn[11:7])
      else $error("R8 rd does not follow the word");
    a_r4_mask_no_trap: assert (!(LEGACY && XLEN == 64) || !illegal)
      else $error("R4 permissive policy trapped");
    a_r7_narrow_trap: assert (XLEN == 64 || hit == illegal)
      else $error("R7 narrow build did not trap");
  end
endmodule

bind wzext_slli wzext_slli_chk #(.XLEN(XLEN), .LEGACY(LEGACY)) u_chk (
  .insn(insn), .src(src), .hit(hit), .rd(rd), .result(result), .illegal(illegal)
);

// File: tb/tb_wzext_slli.sv
module tb_wzext_slli;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] insn;
  logic [63:0] src;
  logic        s_hit, l_hit, n_hit;
  logic [4:0]  s_rd, l_rd, n_rd;
  logic [63:0] s_res, l_res;
  logic [31:0] n_res;
  logic        s_ill, l_ill, n_ill;
  int total = 0;
  int bad = 0;
  bit done = 0;

  wzext_slli #(.XLEN(64), .LEGACY(1'b0)) dut (
    .insn(insn), .src(src), .hit(s_hit), .rd(s_rd), .result(s_res), .illegal(s_ill));
  wzext_slli #(.XLEN(64), .LEGACY(1'b1)) dut_legacy (
    .insn(insn), .src(src), .hit(l_hit), .rd(l_rd), .result(l_res), .illegal(l_ill));
  wzext_slli #(.XLEN(32), .LEGACY(1'b0)) dut_narrow (
    .insn(insn), .src(src[31:0]), .hit(n_hit), .rd(n_rd), .result(n_res), .illegal(n_ill));

  function automatic logic [31:0] enc(logic [4:0] hi, logic [6:0] imm,
                                      logic [2:0] f3, logic [4:0] d, logic [6:0] op);
    return {hi, imm, 5'd7, f3, d, op};
  endfunction

  function automatic logic [70:0] model(bit legacy, bit wide, logic [31:0] w, logic [63:0] s);
    logic h, il;
    logic [4:0] d;
    logic [63:0] r;
    int sh;
    logic [63:0] v;
    h = (w[6:0] == 7'h1b) && (w[14:12] == 3'd1) && (w[31:27] == 5'd1);
    d = h ? w[11:7] : 5'd0;
    if (legacy) sh = int'(w[26:20]) % (wide ? 64 : 32);
    else sh = int'(w[25:20]);
    il = h && (!wide || (!legacy && w[26]));
    v = {32'd0, s[31:0]};
    r = 64'd0;
    if (h && !il) begin
      for (int i = 63; i >= 0; i--) r[i] = (i - sh >= 0) ? v[i - sh] : 1'b0;
    end
    return {h, d, il, r};
  endfunction

  task automatic cmp(string tag, string who, logic [70:0] got, logic [70:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s hit/rd/ill/res got=%h exp=%h", tag, who, got, exp);
    end
  endtask

  task automatic apply(string tag, logic [31:0] w, logic [63:0] s);
    @(posedge clk);
    #0.5;
    insn = w;
    src  = s;
    @(negedge clk);
    cmp(tag, "strict", {s_hit, s_rd, s_ill, s_res}, model(1'b0, 1'b1, w, s));
    cmp(tag, "legacy", {l_hit, l_rd, l_ill, l_res}, model(1'b1, 1'b1, w, s));
    cmp(tag, "narrow", {n_hit, n_rd, n_ill, 32'd0, n_res}, model(1'b0, 1'b0, w, s));
  endtask

  localparam logic [63:0] P0 = 64'hDEAD_BEEF_8000_0001;
  localparam logic [63:0] P1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] P2 = 64'h1234_5678_9ABC_DEF0;

  initial begin
    insn = 32'd0;
    src  = 64'd0;
    apply("R1_reset_idle", 32'd0, 64'd0);
    apply("R1_wrong_op", enc(5'd1, 7'd3, 3'd1, 5'd4, 7'h13), P1);
    apply("R1_right_shift", enc(5'd1, 7'd3, 3'd5, 5'd4, 7'h1b), P1);
    apply("R1_wrong_hi", enc(5'd0, 7'd3, 3'd1, 5'd4, 7'h1b), P1);
    apply("R1_wrong_hi2", enc(5'd3, 7'd3, 3'd1, 5'd4, 7'h1b), P1);
    foreach (P0[i]) ;
    apply("R2_R5_sh0", enc(5'd1, 7'd0, 3'd1, 5'd1, 7'h1b), P0);
    apply("R2_R5_sh31", enc(5'd1, 7'd31, 3'd1, 5'd2, 7'h1b), P0);
    apply("R2_R5_sh32", enc(5'd1, 7'd32, 3'd1, 5'd3, 7'h1b), P1);
    apply("R2_R5_sh63", enc(5'd1, 7'd63, 3'd1, 5'd31, 7'h1b), P0);
    apply("R2_upper_ignored", enc(5'd1, 7'd5, 3'd1, 5'd9, 7'h1b), P2);
    apply("R2_upper_only", enc(5'd1, 7'd5, 3'd1, 5'd9, 7'h1b), 64'hFFFF_FFFF_0000_0000);
    apply("R3_R6_imm64", enc(5'd1, 7'd64, 3'd1, 5'd10, 7'h1b), P2);
    apply("R3_R6_imm95", enc(5'd1, 7'd95, 3'd1, 5'd11, 7'h1b), P1);
    apply("R3_R4_imm127", enc(5'd1, 7'd127, 3'd1, 5'd12, 7'h1b), P0);
    apply("R8_rd0", enc(5'd1, 7'd100, 3'd1, 5'd0, 7'h1b), P0);
    for (int k = 0; k < 128; k += 9)
      apply("R3_R4_R5_R7_sweep", enc(5'd1, 7'(k), 3'd1, 5'(k), 7'h1b), P2 ^ 64'(k * 64'h0101_0101));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule